// File: doc/BRIEF.md
# SD Video Test Pattern Generator

This block produces a continuous stream of 10-bit 4:2:2 standard-definition video words. Luma and chroma are multiplexed in the order Cb, Y, Cr, Y. Every line carries an end-of-active-video timing code, a horizontal blanking run, a start-of-active-video timing code and an active region. The frame follows either a 525-line/30-frame layout or a 625-line/25-frame layout. The active region carries one of four test contents: reference black, a PLL-stress (pathological) field, an equalizer-stress (pathological) field, or eight 75% colour bars. An optional transition filter puts intermediate codes at each colour-bar boundary, which softens the edges seen by a downstream DAC.

The standard, pattern, self-test override and filter controls are captured only at the frame boundary, so a frame on the output is never a mix of two settings. Next to each word, the block gives the current line number and field bit. All line and blanking lengths are parameters. The defaults give 1440 active words and 1716/1728-word lines. A testbench can shrink these to a few dozen words.

Top module: `tpg_sd`

## Requirements
- R1: While `rst` is high, `vid_word`, `line_cnt` and `field` are zero. The outputs are registered: the n-th rising edge after reset is released presents frame position n-1, so the first word after release is 3FFh, the first word of line 0.
- R2: Each line has words 0..3 = 3FFh, 000h, 000h, XYZ (end of active video). These are followed by HB blanking words that alternate 200h (even word index) and 040h (odd word index). Next come 3FFh, 000h, 000h, XYZ (start of active video), then ACT active words. HB must be even.
- R3: The XYZ word is {1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0} from bit 9 down to bit 0. H is 1 in the end code and 0 in the start code. Bit 8 of XYZ equals `field` in the same cycle.
- R4: `line_cnt` runs from 0 to TOTAL-1. F is 1 on lines at or after the field-2 start line. V is 1 on the first VB lines of each field. On V lines the active region carries 200h/040h blanking alternating by word index.
- R5: `std_sel`=0 selects the 525 layout (HB_525, LINES_525, F2_525, VB_525). `std_sel`=1 selects the 625 layout (HB_625, LINES_625, F2_625, VB_625). Line length is ACT+HB+8 words.
- R6: `pat_sel`=00 (reference black) gives Cb=Cr=200h and Y=040h on every active word.
- R7: `pat_sel`=10 (equalizer stress) gives Cb=Cr=300h, Y=198h on the first half of each field's active lines, and reference black on the second half. Active line index i of N active lines is in the first half when 2i < N.
- R8: `pat_sel`=01 (PLL stress) gives reference black on the first half of each field's active lines, and Cb=Cr=200h, Y=110h on the second half.
- R9: `pat_sel`=11 gives eight bars, each ACT/8 words wide, in the order white, yellow, cyan, green, magenta, red, blue, black. Their (Y,Cb,Cr) values are (2D0h,200h,200h), (288h,0B0h,238h), (20Ch,270h,0B0h), (1C0h,120h,0E8h), (150h,2E0h,318h), (104h,190h,350h), (08Ch,350h,1C8h), (040h,200h,200h). Active word index mod 4 selects Cb, Y, Cr, Y.
- R10: With `filt_en`=1 and bars selected, the first three words of bars 1..7 (Cb, Y, Cr) are each the floor average of the same component in the previous bar and in the current bar. The fourth word keeps the current bar's Y. Filter-off edges switch abruptly, and `filt_en` has no effect on the other patterns.
- R11: `bist_en`=1 overrides `pat_sel`: colour bars for the 525 layout, PLL stress for the 625 layout.
- R12: The controls are captured during reset and on the last word of each frame. A change at any other time takes effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Line standard: 0 = 525, 1 = 625 |
| pat_sel | input | 2 | Pattern: 00 black, 01 PLL stress, 10 equalizer stress, 11 bars |
| bist_en | input | 1 | Self-test override of the pattern choice |
| filt_en | input | 1 | Colour-bar transition filter enable |
| vid_word | output | 10 | Multiplexed video word |
| line_cnt | output | LN_W (10 by default) | Line number of the current word |
| field | output | 1 | Field bit of the current word |

## Verification
The word, line number and field of each position are registered once. A position's result is therefore due exactly one rising edge after the edge that steps the counters to it, and the first word appears on the first edge after reset is released. The bench samples on the falling edge following each rising edge and pairs the k-th sample with frame position k-1. It advances its own position model in step with the samples. Control changes are driven mid-frame, right after a sample, and the model applies them only from the next frame start. This checks the capture point at the frame edge without depending on event order.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int WORD_W = 10;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t TRS_ONES  = 10'h3FF;
    localparam word_t TRS_ZEROS = 10'h000;
    localparam word_t C_ZERO    = 10'h200;
    localparam word_t Y_BLACK   = 10'h040;
    localparam word_t EQ_C      = 10'h300;
    localparam word_t EQ_Y      = 10'h198;
    localparam word_t PLL_C     = 10'h200;
    localparam word_t PLL_Y     = 10'h110;

    typedef enum logic {STD_525 = 1'b0, STD_625 = 1'b1} std_e;

    typedef enum logic [1:0] {
        PAT_BLACK = 2'd0,
        PAT_PLL   = 2'd1,
        PAT_EQ    = 2'd2,
        PAT_BARS  = 2'd3
    } pat_e;

    typedef struct packed {
        std_e std;
        pat_e pat;
        logic filt;
    } cfg_t;

    typedef struct packed {
        word_t cb;
        word_t y;
        word_t cr;
    } ycc_t;

    // 75% bar colours, left to right
    function automatic ycc_t bar_ycc(input logic [2:0] idx);
        ycc_t c;
        case (idx)
            3'd0:    c = '{cb: 10'h200, y: 10'h2D0, cr: 10'h200};
            3'd1:    c = '{cb: 10'h0B0, y: 10'h288, cr: 10'h238};
            3'd2:    c = '{cb: 10'h270, y: 10'h20C, cr: 10'h0B0};
            3'd3:    c = '{cb: 10'h120, y: 10'h1C0, cr: 10'h0E8};
            3'd4:    c = '{cb: 10'h2E0, y: 10'h150, cr: 10'h318};
            3'd5:    c = '{cb: 10'h190, y: 10'h104, cr: 10'h350};
            3'd6:    c = '{cb: 10'h350, y: 10'h08C, cr: 10'h1C8};
            default: c = '{cb: 10'h200, y: 10'h040, cr: 10'h200};
        endcase
        return c;
    endfunction

    function automatic word_t half_sum(input word_t a, input word_t b);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[WORD_W:1];
    endfunction

    function automatic ycc_t ycc_mid(input ycc_t a, input ycc_t b);
        ycc_t m;
        m.cb = half_sum(a.cb, b.cb);
        m.y  = half_sum(a.y,  b.y);
        m.cr = half_sum(a.cr, b.cr);
        return m;
    endfunction

    // slot 0 Cb, 2 Cr, 1/3 Y
    function automatic word_t pick_slot(input ycc_t c, input logic [1:0] slot);
        case (slot)
            2'd0:    return c.cb;
            2'd2:    return c.cr;
            default: return c.y;
        endcase
    endfunction

    function automatic word_t trs_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction

endpackage

// File: rtl/tpg_timing.sv
module tpg_timing
    import tpg_pkg::*;
#(
    parameter int ACT_WORDS = 1440,
    parameter int HB_525    = 268,
    parameter int HB_625    = 280,
    parameter int LINES_525 = 525,
    parameter int F2_525    = 263,
    parameter int VB_525    = 20,
    parameter int LINES_625 = 625,
    parameter int F2_625    = 313,
    parameter int VB_625    = 25,
    parameter int HW        = 11,
    parameter int LW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg_in,
    output cfg_t          cfg,
    output logic [HW-1:0] h_cnt,
    output logic [LW-1:0] ln_cnt,
    output logic          fld,
    output logic          vblk,
    output logic          first_half
);

    localparam int LEN_525 = ACT_WORDS + HB_525 + 8;
    localparam int LEN_625 = ACT_WORDS + HB_625 + 8;
    localparam int FL2_525 = LINES_525 - F2_525;
    localparam int FL2_625 = LINES_625 - F2_625;

    logic [HW-1:0] len_m1;
    logic [LW-1:0] last_ln, f2s, vb, fl2, lf, flen, ai, nact;
    logic          line_end, frame_end;

    always_comb begin
        if (cfg.std == STD_625) begin
            len_m1  = HW'(LEN_625 - 1);
            last_ln = LW'(LINES_625 - 1);
            f2s     = LW'(F2_625);
            vb      = LW'(VB_625);
            fl2     = LW'(FL2_625);
        end else begin
            len_m1  = HW'(LEN_525 - 1);
            last_ln = LW'(LINES_525 - 1);
            f2s     = LW'(F2_525);
            vb      = LW'(VB_525);
            fl2     = LW'(FL2_525);
        end
    end

    assign line_end  = (h_cnt == len_m1);
    assign frame_end = line_end && (ln_cnt == last_ln);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt  <= '0;
            ln_cnt <= '0;
            cfg    <= cfg_in;
        end else begin
            h_cnt <= line_end ? '0 : h_cnt + 1'b1;
            if (line_end)
                ln_cnt <= frame_end ? '0 : ln_cnt + 1'b1;
            if (frame_end)
                cfg <= cfg_in;
        end
    end

    // field and vertical position
    assign fld        = (ln_cnt >= f2s);
    assign lf         = fld ? ln_cnt - f2s : ln_cnt;
    assign flen       = fld ? fl2 : f2s;
    assign vblk       = (lf < vb);
    assign ai         = lf - vb;
    assign nact       = flen - vb;
    assign first_half = ({ai, 1'b0} < {1'b0, nact});

    p_hcnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        h_cnt <= len_m1)
        else $error("horizontal count beyond line length");

    p_line_range_r4: assert property (@(posedge clk) disable iff (rst)
        ln_cnt <= last_ln)
        else $error("line count beyond frame length");

    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_end) |-> $stable(cfg))
        else $error("configuration changed inside a frame");

    p_field_start_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fld) |-> (ln_cnt == f2s && h_cnt == '0))
        else $error("field bit rose away from field-2 start");

endmodule

// File: rtl/tpg_pattern.sv
module tpg_pattern
    import tpg_pkg::*;
#(
    parameter int ACT_WORDS      = 1440,
    parameter bit FILTER_PRESENT = 1'b1,
    parameter int AW             = 11
) (
    input  pat_e          pat,
    input  logic          filt,
    input  logic [AW-1:0] a_idx,
    input  logic          first_half,
    output word_t         word
);

    localparam int BAR_W = ACT_WORDS / 8;

    localparam ycc_t BLACK_C = '{cb: C_ZERO, y: Y_BLACK, cr: C_ZERO};
    localparam ycc_t EQ_CC   = '{cb: EQ_C,   y: EQ_Y,    cr: EQ_C};
    localparam ycc_t PLL_CC  = '{cb: PLL_C,  y: PLL_Y,   cr: PLL_C};

    logic [2:0]    bar;
    logic [AW-1:0] rem;
    logic          at_edge;
    ycc_t          cur_c, prv_c, bars_c, sel_c;

    assign bar   = 3'(a_idx / AW'(BAR_W));
    assign rem   = a_idx % AW'(BAR_W);
    assign cur_c = bar_ycc(bar);
    assign prv_c = bar_ycc(bar - 3'd1);

    generate
        if (FILTER_PRESENT) begin : g_filt
            assign at_edge = filt && (bar != 3'd0) && (rem < AW'(3));
        end else begin : g_nofilt
            assign at_edge = 1'b0;
        end
    endgenerate

    assign bars_c = at_edge ? ycc_mid(prv_c, cur_c) : cur_c;

    always_comb begin
        case (pat)
            PAT_EQ:   sel_c = first_half ? EQ_CC : BLACK_C;
            PAT_PLL:  sel_c = first_half ? BLACK_C : PLL_CC;
            PAT_BARS: sel_c = bars_c;
            default:  sel_c = BLACK_C;
        endcase
    end

    assign word = pick_slot(sel_c, a_idx[1:0]);

endmodule

// File: rtl/tpg_sd.sv
module tpg_sd
    import tpg_pkg::*;
#(
    parameter int ACT_WORDS      = 1440,
    parameter int HB_525         = 268,
    parameter int HB_625         = 280,
    parameter int LINES_525      = 525,
    parameter int F2_525         = 263,
    parameter int VB_525         = 20,
    parameter int LINES_625      = 625,
    parameter int F2_625         = 313,
    parameter int VB_625         = 25,
    parameter bit FILTER_PRESENT = 1'b1,
    localparam int LN_W = $clog2((LINES_625 > LINES_525) ? LINES_625 : LINES_525)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            std_sel,
    input  logic [1:0]      pat_sel,
    input  logic            bist_en,
    input  logic            filt_en,
    output logic [9:0]      vid_word,
    output logic [LN_W-1:0] line_cnt,
    output logic            field
);

    localparam int HB_MAX = (HB_625 > HB_525) ? HB_625 : HB_525;
    localparam int HW     = $clog2(ACT_WORDS + HB_MAX + 8);
    localparam int AW     = $clog2(ACT_WORDS);

    cfg_t          cfg_in, cfg;
    logic [HW-1:0] h_cnt, hb_cur, sav_start, act_start, sav_off;
    logic [LN_W-1:0] ln_cnt;
    logic          fld, vblk, first_half;
    word_t         pat_word, blank_w, word_c;

    // self-test override picks the pattern per standard
    assign cfg_in.std  = std_e'(std_sel);
    assign cfg_in.pat  = bist_en ? (std_sel ? PAT_PLL : PAT_BARS) : pat_e'(pat_sel);
    assign cfg_in.filt = filt_en;

    tpg_timing #(
        .ACT_WORDS(ACT_WORDS), .HB_525(HB_525), .HB_625(HB_625),
        .LINES_525(LINES_525), .F2_525(F2_525), .VB_525(VB_525),
        .LINES_625(LINES_625), .F2_625(F2_625), .VB_625(VB_625),
        .HW(HW), .LW(LN_W)
    ) timing_i (
        .clk(clk), .rst(rst), .cfg_in(cfg_in), .cfg(cfg),
        .h_cnt(h_cnt), .ln_cnt(ln_cnt), .fld(fld), .vblk(vblk),
        .first_half(first_half)
    );

    assign hb_cur    = (cfg.std == STD_625) ? HW'(HB_625) : HW'(HB_525);
    assign sav_start = hb_cur + HW'(4);
    assign act_start = hb_cur + HW'(8);
    assign sav_off   = h_cnt - sav_start;

    tpg_pattern #(
        .ACT_WORDS(ACT_WORDS), .FILTER_PRESENT(FILTER_PRESENT), .AW(AW)
    ) pattern_i (
        .pat(cfg.pat), .filt(cfg.filt),
        .a_idx(AW'(h_cnt - act_start)),
        .first_half(first_half), .word(pat_word)
    );

    // blanking parity follows the word index (HB even)
    assign blank_w = h_cnt[0] ? Y_BLACK : C_ZERO;

    always_comb begin
        if (h_cnt < HW'(4)) begin
            case (h_cnt[1:0])
                2'd0:    word_c = TRS_ONES;
                2'd3:    word_c = trs_word(fld, vblk, 1'b1);
                default: word_c = TRS_ZEROS;
            endcase
        end else if (h_cnt < sav_start) begin
            word_c = blank_w;
        end else if (h_cnt < act_start) begin
            case (sav_off[1:0])
                2'd0:    word_c = TRS_ONES;
                2'd3:    word_c = trs_word(fld, vblk, 1'b0);
                default: word_c = TRS_ZEROS;
            endcase
        end else if (vblk) begin
            word_c = blank_w;
        end else begin
            word_c = pat_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_word <= '0;
            line_cnt <= '0;
            field    <= 1'b0;
        end else begin
            vid_word <= word_c;
            line_cnt <= ln_cnt;
            field    <= fld;
        end
    end

    p_preamble_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $past(vid_word) == TRS_ONES |-> vid_word == TRS_ZEROS)
        else $error("timing-code preamble broken");

    p_xyz_protect_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(vid_word, 3) == TRS_ONES && $past(vid_word, 2) == TRS_ZEROS &&
         $past(vid_word, 1) == TRS_ZEROS)
        |-> (vid_word[9] && vid_word[1:0] == 2'b00 &&
             vid_word[8] == field &&
             vid_word[5] == (vid_word[7] ^ vid_word[6]) &&
             vid_word[4] == (vid_word[8] ^ vid_word[6]) &&
             vid_word[3] == (vid_word[8] ^ vid_word[7]) &&
             vid_word[2] == (vid_word[8] ^ vid_word[7] ^ vid_word[6])))
        else $error("timing-code status word malformed");

endmodule

// File: tb/tpg_sd_tb_top.sv
module tpg_sd_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ACT  = 64;
    localparam int HB5  = 8;
    localparam int HB6  = 12;
    localparam int L5   = 10;
    localparam int F25  = 5;
    localparam int VB5  = 2;
    localparam int L6   = 12;
    localparam int F26  = 6;
    localparam int VB6  = 2;
    localparam int LN_W = $clog2((L6 > L5) ? L6 : L5);
    localparam int NCFG = 18;

    localparam int BY [8] = '{720, 648, 524, 448, 336, 260, 140, 64};
    localparam int BCB[8] = '{512, 176, 624, 288, 736, 400, 848, 512};
    localparam int BCR[8] = '{512, 568, 176, 232, 792, 848, 456, 512};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            std_sel = 1'b0;
    logic [1:0]      pat_sel = 2'b00;
    logic            bist_en = 1'b0;
    logic            filt_en = 1'b0;
    logic [9:0]      vid_word;
    logic [LN_W-1:0] line_cnt;
    logic            field;

    int checks = 0;
    int fails  = 0;

    tpg_sd #(
        .ACT_WORDS(ACT), .HB_525(HB5), .HB_625(HB6),
        .LINES_525(L5), .F2_525(F25), .VB_525(VB5),
        .LINES_625(L6), .F2_625(F26), .VB_625(VB6),
        .FILTER_PRESENT(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .std_sel(std_sel), .pat_sel(pat_sel),
        .bist_en(bist_en), .filt_en(filt_en),
        .vid_word(vid_word), .line_cnt(line_cnt), .field(field)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // configuration c: 0..15 sweep std/pattern/filter, 16..17 self-test
    task automatic drive(input int c);
        if (c < 16) begin
            std_sel = c[3];
            pat_sel = c[2:1];
            filt_en = c[0];
            bist_en = 1'b0;
        end else begin
            std_sel = c[0];
            pat_sel = 2'b10;
            filt_en = c[0];
            bist_en = 1'b1;
        end
    endtask

    function automatic int xyz(input int f, input int v, input int h);
        return 512 + f*256 + v*128 + h*64 + ((v^h)*32) + ((f^h)*16) + ((f^v)*8) + ((f^v^h)*4);
    endfunction

    function automatic int model(input int s, input int p, input int fl, input int bist,
                                 input int ln, input int h, output string tag);
        int hb, tot, f2, vb, f, lf, flen, v, a, ai, nact, first, grp, b, r, y, cb, cr;
        hb   = s ? HB6 : HB5;
        tot  = s ? L6 : L5;
        f2   = s ? F26 : F25;
        vb   = s ? VB6 : VB5;
        f    = (ln >= f2) ? 1 : 0;
        lf   = f ? ln - f2 : ln;
        flen = f ? tot - f2 : f2;
        v    = (lf < vb) ? 1 : 0;
        if (h < 4 || (h >= hb + 4 && h < hb + 8)) begin
            int k;
            k   = (h < 4) ? h : h - hb - 4;
            tag = (k == 3) ? "R3" : "R2";
            if (k == 0) return 'h3FF;
            if (k == 3) return xyz(f, v, (h < 4) ? 1 : 0);
            return 0;
        end
        if (h < hb + 4) begin
            tag = "R2";
            return (h % 2) ? 'h040 : 'h200;
        end
        a = h - hb - 8;
        if (v) begin
            tag = "R4";
            return (a % 2) ? 'h040 : 'h200;
        end
        ai    = lf - vb;
        nact  = flen - vb;
        first = (2*ai < nact) ? 1 : 0;
        y = 'h040; cb = 'h200; cr = 'h200;
        tag = bist ? "R11" : (p == 0) ? "R6" : (p == 1) ? "R8" : (p == 2) ? "R7" : "R9";
        if (p == 2 && first) begin y = 'h198; cb = 'h300; cr = 'h300; end
        if (p == 1 && !first) begin y = 'h110; cb = 'h200; cr = 'h200; end
        if (p == 3) begin
            b  = a / (ACT/8);
            r  = a % (ACT/8);
            y  = BY[b]; cb = BCB[b]; cr = BCR[b];
            if (fl && b > 0 && r < 3) begin
                y   = (BY[b-1]  + BY[b])  / 2;
                cb  = (BCB[b-1] + BCB[b]) / 2;
                cr  = (BCR[b-1] + BCR[b]) / 2;
                tag = bist ? "R11" : "R10";
            end
        end
        grp = a % 4;
        return (grp == 0) ? cb : (grp == 2) ? cr : y;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        drive(0);
        rst = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 reset word", vid_word, 0);
        chk("R1 reset line", line_cnt, 0);
        chk("R1 reset field", field, 0);
        rst = 1'b0;
        for (int c = 0; c < NCFG; c++) begin
            int s, p, fl, bist, len, tot, f2;
            if (c < 16) begin
                s = c / 8; p = (c / 2) % 4; fl = c % 2; bist = 0;
            end else begin
                s = c % 2; p = s ? 1 : 3; fl = c % 2; bist = 1;
            end
            len = ACT + (s ? HB6 : HB5) + 8;
            tot = s ? L6 : L5;
            f2  = s ? F26 : F25;
            for (int ln = 0; ln < tot; ln++) begin
                for (int h = 0; h < len; h++) begin
                    string tag;
                    int    exp;
                    @(negedge clk);
                    exp = model(s, p, fl, bist, ln, h, tag);
                    if (ln == 0 && h == 0)
                        tag = (c == 0) ? "R1" : "R12";
                    else if (h == 0)
                        tag = "R5";
                    chk(tag, vid_word, exp);
                    if (h == 3) begin
                        chk("R4 line", line_cnt, ln);
                        chk("R4 field", field, (ln >= f2) ? 1 : 0);
                    end
                    // mid-frame change: must only apply from the next frame (R12)
                    if (ln == 0 && h == 5 && c + 1 < NCFG)
                        drive(c + 1);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule